// File: doc/BRIEF.md
# Staged-Divisor Serial Bit-Rate Generator

This block produces the timing pulses for a serial port. Software sets a 13-bit modulo divisor through a byte-wide register bus that has two locations. The upper location holds the top five divisor bits and three control flags that have nothing to do with the divisor. The lower location holds the bottom eight divisor bits. The bus clock is divided by the divisor to give a one-cycle oversample pulse. Every sixteenth oversample pulse is also marked as a bit-time pulse. The resulting bit rate is the bus clock divided by sixteen times the divisor. For example, a 7.3728 MHz bus with divisor 8 gives 57,600 bit/s.

The active divisor is protected from being seen half-written. Writing the upper location only fills a staging buffer and sets the flags. A later write to the lower location moves the staged upper bits and the new lower byte into the active divisor in one step. If the order is wrong, or the lower write never comes, the new upper bits are never used. A full 16-bit bus write has the same effect as an upper-then-lower pair of byte writes. Each commit restarts both dividers from zero, so the first pulses after a rate change fall at a known distance from the write.

Top module: `baud_tick_gen`

## Requirements
- R1: After reset, `div_active`, `ctl_flags`, both read locations, `os_tick` and `bit_tick` are all zero.
- R2: A byte write to the upper location (`bus_addr`=0, `bus_wide`=0) copies data bits 4:0 into the staging buffer and does not change `div_active`.
- R3: A byte write to the lower location (`bus_addr`=1) sets `div_active` to {staging buffer, data bits 7:0} at the same clock edge.
- R4: Upper bits written after the last lower write stay unused. `div_active` keeps its value until the next lower write commits them.
- R5: Data bits 7:5 of an upper byte write go straight to `ctl_flags` (flag 2 = bit 7). Lower writes never change `ctl_flags`.
- R6: With a nonzero divisor D, `os_tick` is high for one cycle in every cycle k after the commit edge where k is a multiple of D (k counted from 1).
- R7: `bit_tick` is high only together with `os_tick`, on every 16th oversample pulse, so in cycles k that are multiples of 16·D.
- R8: While `div_active` is zero, neither tick is produced.
- R9: A commit restarts both divider counters from zero, even if the committed value equals the old one.
- R10: A wide write (`bus_wide`=1) of a 16-bit word gives the same flags, staging buffer and active divisor as writing bits 15:8 to the upper location and then bits 7:0 to the lower location. It also commits at once.
- R11: Reading location 0 returns {flags, staging buffer}. Reading location 1 returns the low byte of `div_active`. Reads have no side effects.
- R12: A synchronous active-high reset, taken at any time, clears the divisor, the buffer, the flags and both counters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_wr | input | 1 | Write strobe, one write per cycle it is high |
| bus_wide | input | 1 | Write is a full 16-bit word |
| bus_addr | input | 1 | Byte location: 0 upper, 1 lower |
| bus_wdata | input | 16 | Write data; byte writes use bits 7:0 |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| div_active | output | 13 | Divisor the prescaler is using |
| ctl_flags | output | 3 | Control flags from upper-location bits 7:5 |
| os_tick | output | 1 | Oversample pulse, one cycle |
| bit_tick | output | 1 | Bit-time pulse, one cycle |

## Verification
Register effects take one clock edge. A write is driven at a falling edge, and from the falling edge after the capturing rising edge the new `div_active`, `ctl_flags` and read data are due. They are sampled there. Reads are combinational and are sampled 1 ns after the address changes. Tick timing is counted from the commit edge: the falling edge right after it is cycle 1. `os_tick` is expected in cycles that are multiples of D, and `bit_tick` in multiples of 16·D. The bench checks every falling edge of each window against that arithmetic, over divisors 1 to 20, a large divisor, zero, and recommits made in the middle of a count.

// File: rtl/baud_pkg.sv
package baud_pkg;
    localparam int BYTE_W   = 8;
    localparam int DIV_W    = 13;
    localparam int FLAG_W   = 3;
    localparam int OS_RATIO = 16;
    localparam int HI_DIV_W = DIV_W - BYTE_W;

    typedef enum logic {
        LOC_UPPER = 1'b0,
        LOC_LOWER = 1'b1
    } loc_e;
endpackage

// File: rtl/baud_regs.sv
module baud_regs
    import baud_pkg::*;
#(
    parameter int B_W  = BYTE_W,
    parameter int D_W  = DIV_W,
    parameter int F_W  = FLAG_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bus_wr,
    input  logic             bus_wide,
    input  logic             bus_addr,
    input  logic [2*B_W-1:0] bus_wdata,
    output logic [B_W-1:0]   rdata,
    output logic [D_W-1:0]   div_o,
    output logic [F_W-1:0]   flags_o,
    output logic             commit_o
);
    localparam int H_W = D_W - B_W;

    typedef struct packed {
        logic [F_W-1:0] flags;
        logic [H_W-1:0] hi_buf;
        logic [D_W-1:0] div;
    } regs_t;

    regs_t regs_d, regs_q;
    logic  commit_d;
    logic  up_wr, lo_wr;

    always_comb begin
        regs_d   = regs_q;
        commit_d = 1'b0;
        up_wr    = bus_wr && !bus_wide && (loc_e'(bus_addr) == LOC_UPPER);
        lo_wr    = bus_wr && !bus_wide && (loc_e'(bus_addr) == LOC_LOWER);
        if (bus_wr && bus_wide) begin
            regs_d.flags  = bus_wdata[2*B_W-1 -: F_W];
            regs_d.hi_buf = bus_wdata[B_W+H_W-1 : B_W];
            regs_d.div    = {bus_wdata[B_W+H_W-1 : B_W], bus_wdata[B_W-1:0]};
            commit_d      = 1'b1;
        end else if (up_wr) begin
            regs_d.flags  = bus_wdata[B_W-1 -: F_W];
            regs_d.hi_buf = bus_wdata[H_W-1:0];
        end else if (lo_wr) begin
            regs_d.div    = {regs_q.hi_buf, bus_wdata[B_W-1:0]};
            commit_d      = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) regs_q <= '0;
        else     regs_q <= regs_d;
    end

    always_comb begin
        if (loc_e'(bus_addr) == LOC_UPPER) rdata = {regs_q.flags, regs_q.hi_buf};
        else                               rdata = regs_q.div[B_W-1:0];
    end

    assign div_o    = regs_q.div;
    assign flags_o  = regs_q.flags;
    assign commit_o = commit_d;

    // R2: staging an upper byte leaves the running divisor alone
    a_r2_stage_only: assert property (@(posedge clk) disable iff (rst)
        up_wr |=> $stable(div_o));
    // R3: lower write commits buffer and new low byte together
    a_r3_commit_pair: assert property (@(posedge clk) disable iff (rst)
        lo_wr |=> div_o == {$past(regs_q.hi_buf), $past(bus_wdata[B_W-1:0])});
    // R5: lower writes never touch the flags
    a_r5_flags_kept: assert property (@(posedge clk) disable iff (rst)
        lo_wr |=> $stable(flags_o));
    // R10: wide write lands the whole divisor in one edge
    a_r10_wide_commit: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_wide) |=> div_o == $past(bus_wdata[D_W-1:0]));
endmodule

// File: rtl/baud_prescale.sv
module baud_prescale
    import baud_pkg::*;
#(
    parameter int D_W = DIV_W
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [D_W-1:0] div,
    input  logic           restart,
    output logic           os_tick
);
    typedef struct packed {
        logic [D_W-1:0] cnt;
    } pre_t;

    pre_t pre_d, pre_q;
    logic running;
    logic at_end;

    always_comb begin
        running = (div != '0);
        at_end  = running && (pre_q.cnt == div - D_W'(1));
        pre_d   = pre_q;
        if (restart || !running || at_end) pre_d.cnt = '0;
        else                               pre_d.cnt = pre_q.cnt + D_W'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) pre_q <= '0;
        else     pre_q <= pre_d;
    end

    assign os_tick = at_end;

    // R8: a zero divisor keeps the oversample output silent
    a_r8_zero_quiet: assert property (@(posedge clk) disable iff (rst)
        (div == '0) |-> !os_tick);
    // R9: a commit restarts the prescale count
    a_r9_pre_restart: assert property (@(posedge clk) disable iff (rst)
        restart |=> pre_q.cnt == '0);
    // R6: the count never reaches the divisor
    a_r6_cnt_bound: assert property (@(posedge clk) disable iff (rst)
        (div != '0) |-> pre_q.cnt < div);
endmodule

// File: rtl/baud_div16.sv
module baud_div16
    import baud_pkg::*;
#(
    parameter int RATIO = OS_RATIO
) (
    input  logic clk,
    input  logic rst,
    input  logic os_tick,
    input  logic restart,
    output logic bit_tick
);
    localparam int C_W = (RATIO > 1) ? $clog2(RATIO) : 1;
    localparam logic [C_W-1:0] LAST = C_W'(RATIO - 1);

    typedef struct packed {
        logic [C_W-1:0] cnt;
    } d16_t;

    d16_t d16_d, d16_q;
    logic wrap;

    always_comb begin
        wrap  = os_tick && (d16_q.cnt == LAST);
        d16_d = d16_q;
        if (restart)      d16_d.cnt = '0;
        else if (wrap)    d16_d.cnt = '0;
        else if (os_tick) d16_d.cnt = d16_q.cnt + C_W'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) d16_q <= '0;
        else     d16_q <= d16_d;
    end

    assign bit_tick = wrap;

    // R9: a commit restarts the divide-by-ratio count
    a_r9_d16_restart: assert property (@(posedge clk) disable iff (rst)
        restart |=> d16_q.cnt == '0);
    // R7: count stays frozen between oversample pulses
    a_r7_hold_idle: assert property (@(posedge clk) disable iff (rst)
        (!os_tick && !restart) |=> $stable(d16_q.cnt));
endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen
    import baud_pkg::*;
#(
    parameter int B_W   = BYTE_W,
    parameter int D_W   = DIV_W,
    parameter int F_W   = FLAG_W,
    parameter int RATIO = OS_RATIO
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bus_wr,
    input  logic             bus_wide,
    input  logic             bus_addr,
    input  logic [2*B_W-1:0] bus_wdata,
    output logic [B_W-1:0]   bus_rdata,
    output logic [D_W-1:0]   div_active,
    output logic [F_W-1:0]   ctl_flags,
    output logic             os_tick,
    output logic             bit_tick
);
    logic commit;

    baud_regs #(.B_W(B_W), .D_W(D_W), .F_W(F_W)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .bus_wr   (bus_wr),
        .bus_wide (bus_wide),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .rdata    (bus_rdata),
        .div_o    (div_active),
        .flags_o  (ctl_flags),
        .commit_o (commit)
    );

    baud_prescale #(.D_W(D_W)) u_pre (
        .clk    (clk),
        .rst    (rst),
        .div    (div_active),
        .restart(commit),
        .os_tick(os_tick)
    );

    baud_div16 #(.RATIO(RATIO)) u_d16 (
        .clk     (clk),
        .rst     (rst),
        .os_tick (os_tick),
        .restart (commit),
        .bit_tick(bit_tick)
    );

    // R7: a bit pulse always coincides with an oversample pulse
    a_r7_bit_on_os: assert property (@(posedge clk) disable iff (rst)
        bit_tick |-> os_tick);
    // R8: no bit pulse while stopped
    a_r8_no_bit_stopped: assert property (@(posedge clk) disable iff (rst)
        (div_active == '0) |-> !bit_tick);
endmodule

// File: tb/sim_baud_tick_gen.sv
module sim_baud_tick_gen;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic        bus_wide = 1'b0;
    logic        bus_addr = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic [12:0] div_active;
    logic [2:0]  ctl_flags;
    logic        os_tick, bit_tick;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    logic [2:0] fl = 3'b110;

    baud_tick_gen u0 (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_wide(bus_wide),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .div_active(div_active), .ctl_flags(ctl_flags),
        .os_tick(os_tick), .bit_tick(bit_tick)
    );

    always #4 clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            fails = fails + 1;
            $display("FAIL watchdog: actual %0d cycles, expected completion", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_wide = 1'b0; bus_addr = a; bus_wdata = {8'h00, d};
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic wr16(input logic [15:0] v);
        @(negedge clk);
        bus_wr = 1'b1; bus_wide = 1'b1; bus_wdata = v;
        @(negedge clk);
        bus_wr = 1'b0; bus_wide = 1'b0;
    endtask

    task automatic rd(input logic a, output logic [7:0] v);
        @(negedge clk);
        bus_addr = a;
        #1 v = bus_rdata;
    endtask

    task automatic set_div(input int d);
        logic [12:0] dv;
        dv = 13'(d);
        wr(1'b0, {fl, dv[12:8]});
        wr(1'b1, dv[7:0]);
    endtask

    // call right after a commit: first sample is cycle 1
    task automatic run_ticks(input int d, input int n, input string tag);
        int bad_k = 0;
        logic ao = 0, ab = 0, eo = 0, eb = 0;
        for (int k = 1; k <= n; k++) begin
            logic xo, xb;
            if (k > 1) @(negedge clk);
            xo = (d != 0) && (k % d == 0);
            xb = (d != 0) && (k % (16 * d) == 0);
            if (bad_k == 0 && (os_tick !== xo || bit_tick !== xb)) begin
                bad_k = k; ao = os_tick; ab = bit_tick; eo = xo; eb = xb;
            end
        end
        chk(bad_k == 0, tag, {bad_k, 2'b00, ao, ab}, {bad_k, 2'b00, eo, eb});
    endtask

    initial begin
        logic [7:0] rv;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        chk(div_active == 0, "R1 div", div_active, 0);
        chk(ctl_flags == 0, "R1 flags", ctl_flags, 0);
        rd(1'b0, rv); chk(rv == 0, "R1 read upper", rv, 0);
        rd(1'b1, rv); chk(rv == 0, "R1 read lower", rv, 0);
        run_ticks(0, 40, "R1 ticks idle");

        // R2 staging, R5 flags, R11 read upper
        wr(1'b0, 8'hA3);
        chk(div_active == 0, "R2 staged only", div_active, 0);
        chk(ctl_flags == 3'b101, "R5 flags set", ctl_flags, 3'b101);
        rd(1'b0, rv); chk(rv == 8'hA3, "R11 read upper", rv, 8'hA3);
        run_ticks(0, 20, "R2 no ticks after stage");

        // R3 commit, R5 flags kept, R11 read lower
        wr(1'b1, 8'h10);
        chk(div_active == 13'h0310, "R3 commit", div_active, 13'h0310);
        chk(ctl_flags == 3'b101, "R5 flags kept", ctl_flags, 3'b101);
        rd(1'b1, rv); chk(rv == 8'h10, "R11 read lower", rv, 8'h10);
        rd(1'b0, rv); chk(rv == 8'hA3, "R11 read no side effect", rv, 8'hA3);

        // R6 R7 divisor sweep
        for (int d = 1; d <= 20; d++) begin
            set_div(d);
            run_ticks(d, 32 * d + 5, "R6 R7 sweep");
        end
        set_div(261);
        run_ticks(261, 16 * 261 + 5, "R6 R7 large divisor");

        // R4 wrong order leaves high bits unused
        set_div(13'h0107);
        wr(1'b1, 8'h22);
        chk(div_active == 13'h0122, "R4 low commits old buffer", div_active, 13'h0122);
        wr(1'b0, {fl, 5'h1F});
        chk(div_active == 13'h0122, "R4 late high unused", div_active, 13'h0122);
        rd(1'b0, rv); chk(rv == {fl, 5'h1F}, "R11 staged readback", rv, {fl, 5'h1F});
        wr(1'b1, 8'h05);
        chk(div_active == 13'h1F05, "R3 later commit", div_active, 13'h1F05);
        chk(ctl_flags == fl, "R5 flags after low", ctl_flags, fl);

        // R9 restart mid count
        set_div(5);
        run_ticks(5, 23, "R9 pre-run");
        wr(1'b1, 8'd3);
        run_ticks(3, 100, "R9 restart new value");
        repeat (6) @(negedge clk);
        wr(1'b1, 8'd3);
        run_ticks(3, 60, "R9 restart same value");

        // R8 zero stops
        set_div(7);
        run_ticks(7, 40, "R6 before stop");
        set_div(0);
        run_ticks(0, 200, "R8 zero divisor");

        // R10 wide write equivalence
        wr16({3'b011, 5'h00, 8'h09});
        chk(div_active == 9, "R10 wide divisor", div_active, 9);
        chk(ctl_flags == 3'b011, "R10 wide flags", ctl_flags, 3'b011);
        rd(1'b0, rv); chk(rv == 8'h60, "R10 wide upper", rv, 8'h60);
        wr16(16'h4A2C);
        run_ticks(13'h0A2C, 40, "R10 wide restart");
        chk(div_active == 13'h0A2C, "R10 wide hi bits", div_active, 13'h0A2C);
        rd(1'b0, rv); chk(rv == 8'h4A, "R10 wide buffer", rv, 8'h4A);
        rd(1'b1, rv); chk(rv == 8'h2C, "R10 wide low", rv, 8'h2C);
        fl = 3'b010;
        set_div(9);
        run_ticks(9, 300, "R10 byte pair reference");

        // R12 reset mid run
        repeat (5) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk(div_active == 0, "R12 div cleared", div_active, 0);
        chk(ctl_flags == 0, "R12 flags cleared", ctl_flags, 0);
        rd(1'b0, rv); chk(rv == 0, "R12 buffer cleared", rv, 0);
        wr(1'b1, 8'd2);
        chk(div_active == 2, "R12 buffer zero on commit", div_active, 2);
        run_ticks(2, 70, "R12 counters from zero");

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule